// File: doc/BRIEF.md
# Gated Intermediate-Frequency Counter

This block measures the frequency of an intermediate-frequency input by counting its rising edges over a known gate period. The input is asynchronous. It is brought into the system clock domain and edge-detected, and each detected rising edge that falls inside the gate adds one to a saturating binary up-counter. The gate timer counts ticks of an external 1 ms timebase. After a measurement starts, it first waits a settling interval whose length depends on the chosen gate. It then opens the gate for the chosen number of ticks, closes it, and raises a completion indication. That indication is an open-drain style pull-low request. The frozen result can be captured into a shift register and read out most significant bit first.

Software controls the block by issuing a write strobe that carries a run level, a two-bit gate select and a stored sensitivity bit. While the run level is 0, the counter is held at zero and the completion output is released. A write that moves the run level from 0 to 1 starts a measurement. A global inhibit input stops edges from being counted. The frequency follows as count divided by gate time. For example, 3600 edges in an 8 ms gate means 450 kHz, and 342400 edges in 32 ms means 10.7 MHz.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, `count_o` is 0, `done_low_o` is 0 (released), `rd_bit` is 0 and `sens_o` is 0.
- R2: The gate stays open for a number of `ms_tick` pulses set by the latched gate select: 00 gives 4, 01 gives 8, 10 gives 32 and 11 gives 64. The final count equals the number of rising edges of `if_in` that occur while the gate is open.
- R3: Before the gate opens, the timer waits for 4 `ms_tick` pulses when select bit 1 is 0, and for 8 pulses when it is 1. This gives 3 to 4 ms or 7 to 8 ms after the start. Edges during the wait are not counted.
- R4: While the latched run level is 0, `count_o` is held at 0 and `done_low_o` is released. Input edges are ignored.
- R5: A write (`wr_stb`=1) with `wr_run`=1 starts a measurement only if the latched run level was 0. A write of 1 while it is already 1 leaves the result and the completion output unchanged.
- R6: `done_low_o` is 0 from the start through the end of the gate. It becomes 1 (pull low) only after the gate closes, and it stays 1 until a write of run level 0.
- R7: Once the gate has closed, `count_o` holds its value for as long as the run level stays 1.
- R8: An edge whose counting cycle coincides with `inhibit`=1 is not counted.
- R9: The count saturates at all ones (0xFFFFF at the default width) instead of wrapping.
- R10: `rd_load`=1 copies `count_o` into the readout register. `rd_bit` shows its most significant bit, and each `rd_shift`=1 cycle moves the next lower bit onto `rd_bit`.
- R11: Every write stores `wr_sens`, and the stored value appears on `sens_o` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every 1 ms |
| if_in | input | 1 | Asynchronous intermediate-frequency input |
| wr_stb | input | 1 | Control write strobe; fields are latched in this cycle |
| wr_run | input | 1 | Run level: 0 clears, a 0-to-1 change starts |
| wr_gate_sel | input | 2 | Gate period select |
| wr_sens | input | 1 | Sensitivity mode bit, stored only |
| inhibit | input | 1 | Global inhibit; blocks counting |
| rd_load | input | 1 | Capture count into the readout register |
| rd_shift | input | 1 | Shift the readout register one bit toward the MSB |
| rd_bit | output | 1 | Serial result, MSB first |
| count_o | output | CNT_W | Current count |
| done_low_o | output | 1 | 1 requests the completion line be pulled low |
| sens_o | output | 1 | Stored sensitivity bit |

## Verification
The checks assume that `ms_tick` is a single-cycle pulse. They also assume that `if_in` stays at each level for at least two clocks, so that the synchronizer sees every edge. The stimulus meets both assumptions: the bench generates the timebase itself, one cycle in every sixteen. Input pulses are placed in the middle of each tick interval, two clocks high and two low, so that no counted edge lands near a gate boundary. Inhibit windows cover whole interval middles. Write strobes are issued just after a tick.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GATE,
        ST_DONE
    } ifc_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.chain[STAGES-1] & ~sync_q.chain[STAGES];
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
    import ifc_pkg::*;
#(
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int GATE_0     = 4,
    parameter int GATE_1     = 8,
    parameter int GATE_2     = 32,
    parameter int GATE_3     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       start,
    input  logic       clear,
    input  logic [1:0] gate_sel,
    output logic       gate_open,
    output logic       meas_done
);
    localparam int MAXL = max2(max2(max2(WAIT_SHORT, WAIT_LONG), max2(GATE_0, GATE_1)),
                               max2(GATE_2, GATE_3));
    localparam int TW = (MAXL > 1) ? $clog2(MAXL) : 1;
    localparam logic [TW-1:0] WS_LAST = TW'(WAIT_SHORT - 1);
    localparam logic [TW-1:0] WL_LAST = TW'(WAIT_LONG - 1);
    localparam logic [TW-1:0] G0_LAST = TW'(GATE_0 - 1);
    localparam logic [TW-1:0] G1_LAST = TW'(GATE_1 - 1);
    localparam logic [TW-1:0] G2_LAST = TW'(GATE_2 - 1);
    localparam logic [TW-1:0] G3_LAST = TW'(GATE_3 - 1);

    typedef struct packed {
        ifc_state_e    state;
        logic [TW-1:0] tcnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [TW-1:0] wait_last, gate_last;

    always_comb begin
        wait_last = gate_sel[1] ? WL_LAST : WS_LAST;
        case (gate_sel)
            2'b00:   gate_last = G0_LAST;
            2'b01:   gate_last = G1_LAST;
            2'b10:   gate_last = G2_LAST;
            default: gate_last = G3_LAST;
        endcase

        tmr_d = tmr_q;
        unique case (tmr_q.state)
            ST_IDLE: ;
            ST_WAIT: if (ms_tick) begin
                if (tmr_q.tcnt == wait_last) begin
                    tmr_d.state = ST_GATE;
                    tmr_d.tcnt  = '0;
                end else begin
                    tmr_d.tcnt = tmr_q.tcnt + 1'b1;
                end
            end
            ST_GATE: if (ms_tick) begin
                if (tmr_q.tcnt == gate_last) begin
                    tmr_d.state = ST_DONE;
                    tmr_d.tcnt  = '0;
                end else begin
                    tmr_d.tcnt = tmr_q.tcnt + 1'b1;
                end
            end
            ST_DONE: ;
            default: tmr_d.state = ST_IDLE;
        endcase

        if (start) begin
            tmr_d.state = ST_WAIT;
            tmr_d.tcnt  = '0;
        end else if (clear) begin
            tmr_d.state = ST_IDLE;
            tmr_d.tcnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.state <= ST_IDLE;
            tmr_q.tcnt  <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign gate_open = (tmr_q.state == ST_GATE);
    assign meas_done = (tmr_q.state == ST_DONE);
endmodule

// File: rtl/ifc_pulse_cnt.sv
module ifc_pulse_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d.val = '0;
        else if (inc && (cnt_q.val != TOP))
            cnt_d.val = cnt_q.val + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q.val;
endmodule

// File: rtl/ifc_shift_out.sv
module ifc_shift_out #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [CNT_W-1:0] data,
    output logic             msb
);
    typedef struct packed {
        logic [CNT_W-1:0] sr;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load)
            shf_d.sr = data;
        else if (shift)
            shf_d.sr = {shf_q.sr[CNT_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign msb = shf_q.sr[CNT_W-1];
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter #(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_SHORT  = 4,
    parameter int WAIT_LONG   = 8,
    parameter int GATE_0      = 4,
    parameter int GATE_1      = 8,
    parameter int GATE_2      = 32,
    parameter int GATE_3      = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             if_in,
    input  logic             wr_stb,
    input  logic             wr_run,
    input  logic [1:0]       wr_gate_sel,
    input  logic             wr_sens,
    input  logic             inhibit,
    input  logic             rd_load,
    input  logic             rd_shift,
    output logic             rd_bit,
    output logic [CNT_W-1:0] count_o,
    output logic             done_low_o,
    output logic             sens_o
);
    typedef struct packed {
        logic       run;
        logic [1:0] sel;
        logic       sens;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  start_pls, run_lvl, edge_pls, gate_open, meas_done, cnt_inc;

    // control latch: all fields taken at each write strobe
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_stb) begin
            ctrl_d.run  = wr_run;
            ctrl_d.sel  = wr_gate_sel;
            ctrl_d.sens = wr_sens;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign run_lvl   = ctrl_q.run;
    assign start_pls = wr_stb & wr_run & ~ctrl_q.run;

    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (if_in),
        .rise     (edge_pls)
    );

    ifc_gate_timer #(
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG),
        .GATE_0     (GATE_0),
        .GATE_1     (GATE_1),
        .GATE_2     (GATE_2),
        .GATE_3     (GATE_3)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .start     (start_pls),
        .clear     (~run_lvl),
        .gate_sel  (ctrl_q.sel),
        .gate_open (gate_open),
        .meas_done (meas_done)
    );

    assign cnt_inc = edge_pls & gate_open & ~inhibit;

    ifc_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~run_lvl),
        .inc   (cnt_inc),
        .cnt   (count_o)
    );

    ifc_shift_out #(.CNT_W(CNT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .shift (rd_shift),
        .data  (count_o),
        .msb   (rd_bit)
    );

    assign done_low_o = meas_done;
    assign sens_o     = ctrl_q.sens;
endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_lvl,
    input logic             gate_open,
    input logic             inhibit,
    input logic [CNT_W-1:0] count_o,
    input logic             done_low_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_lvl |=> (count_o == '0));

    assert_no_decrease_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_lvl |=> (count_o >= $past(count_o)));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_lvl && !gate_open) |=> $stable(count_o));

    assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_lvl && inhibit) |=> $stable(count_o));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_lvl && count_o == TOP) |=> (count_o == TOP));

    assert_done_after_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_low_o) |-> $past(gate_open));
endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_lvl    (run_lvl),
    .gate_open  (gate_open),
    .inhibit    (inhibit),
    .count_o    (count_o),
    .done_low_o (done_low_o)
);

// File: tb/tb_ifc_gated_counter.sv
module tb_ifc_gated_counter;
    localparam int CLK_PERIOD = 10;
    localparam int TD         = 16;
    localparam int CNT_W      = 20;
    localparam int SAT_W      = 6;
    localparam int SAT_MAX    = (1 << SAT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick, if_in = 1'b0, wr_stb = 1'b0, wr_run = 1'b0, wr_sens = 1'b0;
    logic [1:0] wr_gate_sel = 2'b00;
    logic inhibit = 1'b0, rd_load = 1'b0, rd_shift = 1'b0;
    logic rd_bit, done_low_o, sens_o;
    logic [CNT_W-1:0] count_o;
    logic rd_bit_s, done_s, sens_s;
    logic [SAT_W-1:0] count_s;
    int ph = 1;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) ph <= (!rst_n) ? 1 : ((ph == TD-1) ? 0 : ph + 1);
    assign ms_tick = rst_n && (ph == 0);

    ifc_gated_counter dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .if_in(if_in),
        .wr_stb(wr_stb), .wr_run(wr_run), .wr_gate_sel(wr_gate_sel), .wr_sens(wr_sens),
        .inhibit(inhibit), .rd_load(rd_load), .rd_shift(rd_shift),
        .rd_bit(rd_bit), .count_o(count_o), .done_low_o(done_low_o), .sens_o(sens_o));

    ifc_gated_counter #(.CNT_W(SAT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .if_in(if_in),
        .wr_stb(wr_stb), .wr_run(wr_run), .wr_gate_sel(wr_gate_sel), .wr_sens(wr_sens),
        .inhibit(inhibit), .rd_load(rd_load), .rd_shift(rd_shift),
        .rd_bit(rd_bit_s), .count_o(count_s), .done_low_o(done_s), .sens_o(sens_s));

    task automatic nc();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wait_len(input logic [1:0] s);
        return s[1] ? 8 : 4;
    endfunction

    function automatic int gate_len(input logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic write(input logic run, input logic [1:0] s, input logic sens);
        while (ph != 2) nc();
        wr_stb = 1'b1; wr_run = run; wr_gate_sel = s; wr_sens = sens;
        nc();
        wr_stb = 1'b0;
    endtask

    task automatic meas(input logic [1:0] s, input int pp, input int ip, output int exp);
        int w, g, idx;
        bit p1, p2, ih;
        logic sens;
        w = wait_len(s); g = gate_len(s); exp = 0; idx = 0;
        sens = 1'($urandom_range(1));
        write(1'b1, s, sens);
        chk(sens_o == sens, "R11 sens stored", sens_o, sens);
        p1 = ($urandom_range(99) < pp); p2 = ($urandom_range(99) < pp);
        ih = ($urandom_range(99) < ip);
        while (idx <= w + g) begin
            int p;
            p = ph;
            if (p == 1) begin
                p1 = ($urandom_range(99) < pp); p2 = ($urandom_range(99) < pp);
                ih = ($urandom_range(99) < ip);
            end
            if_in   = (p1 && (p == 4 || p == 5)) || (p2 && (p == 8 || p == 9));
            inhibit = ih && (p >= 3) && (p <= 13);
            if (p == 5 && idx >= w && idx < w + g && !ih) exp += int'(p1) + int'(p2);
            if (p == 6 && (idx == 0 || idx == w + g - 1))
                chk(done_low_o == 1'b0, "R6 released before gate end", done_low_o, 0);
            nc();
            if (p == 0) idx++;
        end
        if_in = 1'b0; inhibit = 1'b0;
        repeat (3) nc();
        chk(done_low_o == 1'b1, "R6 done after gate", done_low_o, 1);
        chk(count_o == CNT_W'(exp), "R2/R3/R8 count in gate", count_o, exp);
        chk(int'(count_s) == ((exp > SAT_MAX) ? SAT_MAX : exp), "R9 saturating count",
            count_s, (exp > SAT_MAX) ? SAT_MAX : exp);
    endtask

    task automatic readout(input int exp);
        int val;
        val = 0;
        rd_load = 1'b1; nc(); rd_load = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            val = (val << 1) | int'(rd_bit);
            rd_shift = 1'b1; nc(); rd_shift = 1'b0;
        end
        chk(val == exp, "R10 serial readout MSB first", val, exp);
    endtask

    task automatic clear_run();
        write(1'b0, 2'b00, 1'b0);
        repeat (3) nc();
        chk(count_o == '0, "R4 count cleared", count_o, 0);
        chk(done_low_o == 1'b0, "R4 done released on clear", done_low_o, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int e;
        void'($urandom(32'd4242));
        repeat (5) nc();
        chk(count_o == '0, "R1 reset count", count_o, 0);
        chk(done_low_o == 1'b0, "R1 reset done", done_low_o, 0);
        chk(rd_bit == 1'b0, "R1 reset rd_bit", rd_bit, 0);
        chk(sens_o == 1'b0, "R1 reset sens", sens_o, 0);
        rst_n = 1'b1;
        nc();

        // R4: edges with run level 0 are ignored
        for (int i = 0; i < 20; i++) begin
            if_in = 1'b1; nc(); nc(); if_in = 1'b0; nc(); nc();
        end
        chk(count_o == '0, "R4 idle edges ignored", count_o, 0);

        // directed: every gate select, all pulses present, no inhibit
        for (int s = 0; s < 4; s++) begin
            meas(2'(s), 100, 0, e);
            chk(e == 2 * gate_len(2'(s)), "R2 full-density expected", e, 2 * gate_len(2'(s)));
            readout(e);
            // R5: rewrite of run=1 while running does not restart
            write(1'b1, 2'(s ^ 1), 1'b0);
            repeat (30) nc();
            chk(count_o == CNT_W'(e), "R5 rewrite keeps result", count_o, e);
            chk(done_low_o == 1'b1, "R5 rewrite keeps done", done_low_o, 1);
            // R7: frozen after gate while run stays 1
            if_in = 1'b1; nc(); nc(); if_in = 1'b0; repeat (4) nc();
            chk(count_o == CNT_W'(e), "R7 frozen after gate", count_o, e);
            clear_run();
        end

        // random mix with inhibit
        for (int k = 0; k < 10; k++) begin
            meas(2'($urandom_range(3)), 60, 30, e);
            readout(e);
            clear_run();
        end

        summary();
        $finish;
    end
endmodule